// File: doc/BRIEF.md
# Pin Bank Register Controller

This block is the register front end of a single 16-pin general-purpose I/O bank. It sits on a plain 32-bit bus with a write strobe, a byte address and combinational read data. Each pin has a 4-bit field in one of two configuration words. The field picks the direction, the drive style and the data source. The block turns these fields, together with an output data word, into pad controls: output enable, output level and pull-up or pull-down requests. A pin's level comes either from the output word or from an alternate-function signal supplied by another on-chip peripheral.

Software reads the pad levels back through a two-stage synchronizer. It changes output bits without a read-modify-write by using a set/clear word or a clear-only word. Lower field bits 00 mean input and any other value means output; the output speed codes only matter to the pad cell. In input mode the output word doubles as the pull direction selector.

Top module: `pinbank`

## Requirements
- R1: After reset both configuration words read 0x44444444 (every pin a floating input, field 0100), the output word reads 0, and padOe, padOut, padPullUp and padPullDn are all 0.
- R2: The configuration words sit at byte offsets 0x00 (pins 0-7) and 0x04 (pins 8-15), with pin n's field at bits 4(n mod 8)+3 down to 4(n mod 8). Field bits 1:0 are the mode (00 input, 01/10/11 output) and bits 3:2 the style. Both words read back exactly what was written.
- R3: The output word at 0x0C stores write data bits 15:0 and reads with bits 31:16 as 0.
- R4: A write to 0x10 sets output bit n for each 1 in data bit n and clears output bit n for each 1 in data bit n+16. Set wins when both bits are 1. Zero bits change nothing. The word reads 0.
- R5: A write to 0x14 clears output bit n for each 1 in data bit n (n = 0-15). Bits 31:16 are ignored and the word reads 0.
- R6: The input word at 0x08 shows pad levels that were present for two rising clock edges. A level applied before edge k appears after edge k+1. Pins in analog input mode (field 0000) read 0. Bits 31:16 read 0 and writes to this word have no effect.
- R7: An output pin in push-pull style (style bit 2 = 0) has padOe = 1 and padOut equal to its source.
- R8: An output pin in open-drain style (style bit 2 = 1) has padOut = 0 and padOe = 1 exactly when its source is 0.
- R9: An output pin's source is its output word bit when style bit 3 is 0, and its altOut bit when style bit 3 is 1.
- R10: An input pin never drives (padOe = 0, padOut = 0). With style 10 it requests a pull-up when its output bit is 1 and a pull-down when it is 0. Other input styles request no pull, and pull-up and pull-down are never both active.
- R11: Reads of unmapped offsets (0x18, 0x1C) return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one write per cycle |
| busAddr | input | 5 | Byte address, bits 1:0 ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| padIn | input | 16 | Asynchronous pad levels |
| altOut | input | 16 | Alternate-function output level per pin |
| padOe | output | 16 | Pad output enable |
| padOut | output | 16 | Pad output level |
| padPullUp | output | 16 | Pull-up request |
| padPullDn | output | 16 | Pull-down request |

## Verification
A corrupted output or configuration bit shows on padOe, padOut or the pull requests in the same cycle, because the pad controls are purely combinational from those registers. A fault in the set/clear or clear-only merge is caught on the read-back of offset 0x0C one cycle after the write. A synchronizer fault shows as a level that reaches offset 0x08 one edge early or late, so the bench samples both before and after the second edge. Mode decoding is checked on four pins at once, covering every pairing of style and source with both source levels.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int PIN_COUNT    = 16;
  localparam int FIELD_W      = 4;
  localparam int DATA_W       = 32;
  localparam int ADDR_W       = 5;
  localparam int PINS_PER_CFG = DATA_W / FIELD_W;
  localparam int CFG_REGS     = PIN_COUNT / PINS_PER_CFG;
  localparam int IDX_W        = (CFG_REGS > 1) ? $clog2(CFG_REGS) : 1;
  localparam int WORD_W       = ADDR_W - 2;
  // word offsets after the configuration words
  localparam int WORD_IN      = CFG_REGS;
  localparam int WORD_OUT     = CFG_REGS + 1;
  localparam int WORD_SET     = CFG_REGS + 2;
  localparam int WORD_CLR     = CFG_REGS + 3;
  localparam logic [FIELD_W-1:0] FIELD_RST = 4'b0100;

  typedef enum logic [2:0] {
    RD_NONE, RD_CFG, RD_IN, RD_OUT
  } rdSel_e;

  typedef struct packed {
    logic [CFG_REGS-1:0] wrCfg;
    logic                wrOut;
    logic                wrSet;
    logic                wrClr;
    rdSel_e              rdSel;
    logic [IDX_W-1:0]    cfgIdx;
  } strobe_t;
endpackage

// File: rtl/pinbank_ctl.sv
module pinbank_ctl
  import pinbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  logic [WORD_W-1:0] wordIdx;
  assign wordIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    for (int i = 0; i < CFG_REGS; i++) begin
      if (wordIdx == WORD_W'(i)) begin
        stb.rdSel    = RD_CFG;
        stb.cfgIdx   = IDX_W'(i);
        stb.wrCfg[i] = busWe;
      end
    end
    if (wordIdx == WORD_W'(WORD_IN))  stb.rdSel = RD_IN;
    if (wordIdx == WORD_W'(WORD_OUT)) begin
      stb.rdSel = RD_OUT;
      stb.wrOut = busWe;
    end
    if (wordIdx == WORD_W'(WORD_SET)) stb.wrSet = busWe;
    if (wordIdx == WORD_W'(WORD_CLR)) stb.wrClr = busWe;
  end

  // R11: at most one register is written per cycle
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrCfg, stb.wrOut, stb.wrSet, stb.wrClr}));
  // R11: no write strobe without a bus write
  p_no_idle_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busWe |-> ({stb.wrCfg, stb.wrOut, stb.wrSet, stb.wrClr} == '0));
endmodule

// File: rtl/pinbank_dp.sv
module pinbank_dp
  import pinbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] altOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padPullUp,
  output logic [PIN_COUNT-1:0] padPullDn
);
  logic [CFG_REGS-1:0][DATA_W-1:0]    cfgQ;
  logic [PIN_COUNT-1:0][FIELD_W-1:0]  field;
  logic [PIN_COUNT-1:0] outQ, syncA, syncB;
  logic [PIN_COUNT-1:0] anaMask, inMask, odMask, inView;
  logic [PIN_COUNT-1:0] setBits, clrBits;

  assign field   = cfgQ;
  assign setBits = busWdata[PIN_COUNT-1:0];
  assign clrBits = busWdata[2*PIN_COUNT-1:PIN_COUNT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= {(CFG_REGS*PINS_PER_CFG){FIELD_RST}};
    end else begin
      for (int c = 0; c < CFG_REGS; c++)
        if (stb.wrCfg[c]) cfgQ[c] <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          outQ <= '0;
    else if (stb.wrOut) outQ <= setBits;
    else if (stb.wrSet) outQ <= (outQ & ~clrBits) | setBits;  // set wins
    else if (stb.wrClr) outQ <= outQ & ~setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [1:0] mode, style;
    logic       isIn, src, openDrain;
    assign mode      = field[p][1:0];
    assign style     = field[p][3:2];
    assign isIn      = (mode == 2'b00);
    assign openDrain = style[0];
    assign src       = style[1] ? altOut[p] : outQ[p];
    assign padOe[p]     = !isIn && (openDrain ? !src : 1'b1);
    assign padOut[p]    = !isIn && !openDrain && src;
    assign padPullUp[p] = isIn && (style == 2'b10) && outQ[p];
    assign padPullDn[p] = isIn && (style == 2'b10) && !outQ[p];
    assign anaMask[p]   = isIn && (style == 2'b00);
    assign inMask[p]    = isIn;
    assign odMask[p]    = !isIn && openDrain;
  end

  assign inView = syncB & ~anaMask;

  always_comb begin
    case (stb.rdSel)
      RD_CFG:  busRdata = cfgQ[stb.cfgIdx];
      RD_IN:   busRdata = DATA_W'(inView);
      RD_OUT:  busRdata = DATA_W'(outQ);
      default: busRdata = '0;
    endcase
  end

  // R4: every bit named in a set/clear write is 1 afterwards
  p_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSet |=> ((outQ & $past(setBits)) == $past(setBits)));
  // R5: every bit named in a clear-only write is 0 afterwards
  p_clr_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrClr |=> ((outQ & $past(setBits)) == '0));
  // R3: output word only moves on one of its three write paths
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrOut || stb.wrSet || stb.wrClr) |=> $stable(outQ));
  // R2: configuration only moves on a configuration write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCfg == '0) |=> $stable(cfgQ));
  // R10: input pins never drive
  p_in_no_drive_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((padOe | padOut) & inMask) == '0);
  // R8: open-drain pins never drive high
  p_od_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & odMask) == '0);
  // R10: pulls are exclusive
  p_pull_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDn) == '0);
endmodule

// File: rtl/pinbank.sv
module pinbank
  import pinbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busWe,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  input  logic [PIN_COUNT-1:0] altOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padPullUp,
  output logic [PIN_COUNT-1:0] padPullDn
);
  strobe_t stb;

  pinbank_ctl i_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .busWe   (busWe),
    .busAddr (busAddr),
    .stb     (stb)
  );

  pinbank_dp i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .altOut    (altOut),
    .padOe     (padOe),
    .padOut    (padOut),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn)
  );
endmodule

// File: tb/test_pinbank.sv
`timescale 1ns/1ps
module test_pinbank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [15:0] padIn = '0;
  logic [15:0] altOut = '0;
  logic [15:0] padOe, padOut, padPullUp, padPullDn;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pinbank i_pinbank (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn), .altOut(altOut),
    .padOe(padOe), .padOut(padOut), .padPullUp(padPullUp), .padPullDn(padPullDn)
  );

  typedef struct packed {
    logic        we;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 5'h00, 32'h0,         32'h44444444, 4'd1},  // R1
    '{1'b0, 5'h04, 32'h0,         32'h44444444, 4'd1},  // R1
    '{1'b0, 5'h0C, 32'h0,         32'h00000000, 4'd1},  // R1
    '{1'b1, 5'h0C, 32'hFFFFA5A5,  32'h0,        4'd3},  // R3
    '{1'b0, 5'h0C, 32'h0,         32'h0000A5A5, 4'd3},  // R3
    '{1'b1, 5'h10, 32'h00010002,  32'h0,        4'd4},  // R4 set 1, clear 0
    '{1'b0, 5'h0C, 32'h0,         32'h0000A5A6, 4'd4},
    '{1'b1, 5'h10, 32'h00080008,  32'h0,        4'd4},  // R4 both on pin 3
    '{1'b0, 5'h0C, 32'h0,         32'h0000A5AE, 4'd4},
    '{1'b0, 5'h10, 32'h0,         32'h00000000, 4'd4},
    '{1'b1, 5'h14, 32'hFFFF00FF,  32'h0,        4'd5},  // R5
    '{1'b0, 5'h0C, 32'h0,         32'h0000A500, 4'd5},
    '{1'b0, 5'h14, 32'h0,         32'h00000000, 4'd5},
    '{1'b1, 5'h08, 32'hFFFFFFFF,  32'h0,        4'd6},  // R6 write ignored
    '{1'b0, 5'h08, 32'h0,         32'h00000000, 4'd6},
    '{1'b0, 5'h0C, 32'h0,         32'h0000A500, 4'd6},
    '{1'b1, 5'h00, 32'h12345678,  32'h0,        4'd2},  // R2
    '{1'b0, 5'h00, 32'h0,         32'h12345678, 4'd2},
    '{1'b1, 5'h04, 32'h9ABCDEF0,  32'h0,        4'd2},
    '{1'b0, 5'h04, 32'h0,         32'h9ABCDEF0, 4'd2},
    '{1'b1, 5'h18, 32'hFFFFFFFF,  32'h0,        4'd11}, // R11
    '{1'b0, 5'h18, 32'h0,         32'h00000000, 4'd11},
    '{1'b0, 5'h1C, 32'h0,         32'h00000000, 4'd11},
    '{1'b0, 5'h00, 32'h0,         32'h12345678, 4'd11},
    '{1'b0, 5'h0C, 32'h0,         32'h0000A500, 4'd11}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    busAddr = a;
    #1 check(tag, busRdata, exp);
  endtask

  task automatic pads(input string tag, input logic [15:0] eOe, input logic [15:0] eOut,
                      input logic [15:0] eUp, input logic [15:0] eDn);
    @(negedge clk);
    #1;
    check({tag, " padOe"}, {16'h0, padOe}, {16'h0, eOe});
    check({tag, " padOut"}, {16'h0, padOut}, {16'h0, eOut});
    check({tag, " padPullUp"}, {16'h0, padPullUp}, {16'h0, eUp});
    check({tag, " padPullDn"}, {16'h0, padPullDn}, {16'h0, eDn});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 50000) begin
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 50000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 pads("R1 pads in reset", 16'h0, 16'h0, 16'h0, 16'h0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].we) wr(VECS[i].addr, VECS[i].data);
      else rd($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].addr, VECS[i].exp);
    end

    // restore floating inputs and clear outputs
    wr(5'h00, 32'h44444444);
    wr(5'h04, 32'h44444444);
    wr(5'h0C, 32'h0);

    // R6: two-edge latency of the input word
    @(negedge clk);
    padIn = 16'hBEEF;
    rd("R6 after one edge", 5'h08, 32'h0);
    rd("R6 after two edges", 5'h08, 32'h0000BEEF);
    // R6: analog pin 0 reads 0
    wr(5'h00, 32'h44444440);
    rd("R6 analog masked", 5'h08, 32'h0000BEEE);

    // R10: pin 0 and pin 1 pull mode, output word picks direction
    wr(5'h00, 32'h44444488);
    wr(5'h0C, 32'h00000001);
    pads("R10 pull select", 16'h0, 16'h0, 16'h0001, 16'h0002);

    // R7 R8 R9: pin0 PP/out, pin1 OD/out, pin2 PP/alt, pin3 OD/alt
    wr(5'h00, 32'h4444FB73);
    wr(5'h0C, 32'h00000003);
    altOut = 16'h0004;
    pads("R7 R8 R9 pattern A", 16'h000D, 16'h0005, 16'h0, 16'h0);
    wr(5'h0C, 32'h00000000);
    altOut = 16'h0008;
    pads("R7 R8 R9 pattern B", 16'h0007, 16'h0000, 16'h0, 16'h0);

    // R2: pin 15 in the high word, push-pull from output word
    wr(5'h04, 32'h14444444);
    wr(5'h10, 32'h00008000);
    pads("R2 high word pin15", 16'h8007, 16'h8000, 16'h0, 16'h0);

    // R1: reset in the middle of operation
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R1 padOe after reset", {16'h0, padOe}, 32'h0);
    rd("R1 cfg low after reset", 5'h00, 32'h44444444);
    rd("R1 cfg high after reset", 5'h04, 32'h44444444);
    rd("R1 output after reset", 5'h0C, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule